// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block receives one serial ARINC 429 style stream and hands each accepted word to a host bus. It takes two digital line levels, high and low, from an external line receiver. It samples them ten times per bit and recovers data bits from the return-to-zero pulses. Words are framed as 32 or 25 bits. A word that stops part way through is thrown away. A completed word can optionally be checked against a two-bit source/destination code. Its parity status is computed as it is accepted.

An accepted word is repacked into two 16-bit half-words and kept in a holding register, and a data-ready flag is raised. The host chooses a half with a select input and reads it while holding an enable strobe. The half-words can be read in any order and as many times as needed. Reading the second half clears the flag. A newer accepted word replaces the held one, whether or not the old one was read.

Top module: `a429_rx_channel`

## Requirements
- R1: One sample is taken per clock when `cfg_rate_slow` is 0, and one every 8 clocks when it is 1. A bit is recovered once a one level (`line_hi`=1, `line_lo`=0) or a zero level (`line_hi`=0, `line_lo`=1) has been seen on two consecutive samples. A single-sample pulse produces no bit.
- R2: `cfg_len25`=0 selects 32-bit words and `cfg_len25`=1 selects 25-bit words. The first bit received is ARINC bit 1, and a word completes when its last bit arrives.
- R3: A null level (both lines equal) that lasts 25 consecutive samples inside a word discards the bits received so far. The next bit starts a fresh word.
- R4: With `cfg_filt_en`=1 in 32-bit mode, a completed word is accepted only if ARINC bit 9 equals `cfg_match_y` and ARINC bit 10 equals `cfg_match_x`. Any other word leaves the holding register and `data_ready` unchanged. With filtering off, or in 25-bit mode, every completed word is accepted.
- R5: Parity status is 1 when the received word held an even number of ones and 0 when it held an odd number. It appears on bit 8 of the first half-word.
- R6: In 32-bit mode, the first half-word carries ARINC bits 13, 12, 11, 10, 9, 31, 30 on bits 15 down to 9, parity status on bit 8, and ARINC bits 1 through 8 on bits 7 down to 0. The second half-word carries ARINC bits 29 down to 14 on bits 15 down to 0.
- R7: In 25-bit mode, the first half-word carries zeros on bits 15 to 9, parity status on bit 8, and ARINC bits 1 through 8 on bits 7 down to 0. The second half-word carries ARINC bits 24 down to 9 on bits 15 down to 0.
- R8: While `rd_en`=1, `rd_data` shows the first half-word when `rd_sel`=0 and the second when `rd_sel`=1. While `rd_en`=0 it is zero. Reading does not alter the held word.
- R9: `data_ready` is set when a word is accepted. It is cleared by a read strobe whose rising edge sees `rd_sel`=1, and it is not cleared by a first-half read. A newly accepted word overwrites an unread one.
- R10: After reset, `data_ready` is 0 and any partly received word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, ten times the fast bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_hi | input | 1 | Digital high-level indication from the line receiver |
| line_lo | input | 1 | Digital low-level indication from the line receiver |
| cfg_rate_slow | input | 1 | 1 selects the bit period of 80 clocks, 0 the period of 10 |
| cfg_len25 | input | 1 | 1 selects 25-bit words, 0 selects 32-bit words |
| cfg_filt_en | input | 1 | Enables the source/destination filter |
| cfg_match_x | input | 1 | Value required on ARINC bit 10 |
| cfg_match_y | input | 1 | Value required on ARINC bit 9 |
| rd_sel | input | 1 | Half-word select: 0 first, 1 second |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Selected half-word, zero while not reading |
| data_ready | output | 1 | An accepted word is waiting |

## Verification
The last bit of a word is taken on its second qualifying sample, one clock after that sample's edge. The framer reports word completion on the next clock, and `data_ready` plus the held halves update one clock after that. The bench therefore checks the flag and the data only after the word's trailing null gap of at least 40 samples, well past that three-clock chain. `rd_data` is combinational from the held word and the strobe, so it is sampled in the same low clock phase in which the strobe is driven. The flag clear lands on the following rising edge and is checked one clock phase later.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic [1:0] {
    LVL_NULL = 2'd0,
    LVL_ZERO = 2'd1,
    LVL_ONE  = 2'd2
  } line_lvl_e;

  localparam int unsigned WORD_LONG  = 32;
  localparam int unsigned WORD_SHORT = 25;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned LABEL_W    = 8;
endpackage

// File: rtl/a429_bit_recover.sv
module a429_bit_recover
  import a429_rx_pkg::*;
#(
  parameter int unsigned SLOW_DIV   = 8,
  parameter int unsigned NULL_LIMIT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_hi,
  input  logic line_lo,
  input  logic rate_slow,
  output logic bit_stb,
  output logic bit_val,
  output logic gap_stb
);
  localparam int unsigned PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int unsigned NW = $clog2(NULL_LIMIT + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [NW-1:0] null_q, null_d;
  line_lvl_e     lvl, prev_q, prev_d;
  logic          taken_q, taken_d;
  logic          tick, hit;
  logic          bit_stb_d, bit_val_d, gap_stb_d;
  logic          bit_stb_q, bit_val_q, gap_stb_q;

  always_comb begin
    if (line_hi && !line_lo)      lvl = LVL_ONE;
    else if (line_lo && !line_hi) lvl = LVL_ZERO;
    else                          lvl = LVL_NULL;
  end

  always_comb begin
    pre_d = (pre_q == PW'(SLOW_DIV - 1)) ? '0 : pre_q + 1'b1;
    tick  = rate_slow ? (pre_q == PW'(SLOW_DIV - 1)) : 1'b1;
    hit   = (lvl != LVL_NULL) && (lvl == prev_q) && !taken_q;
    prev_d = prev_q;
    taken_d = taken_q;
    null_d = null_q;
    bit_stb_d = 1'b0;
    bit_val_d = bit_val_q;
    gap_stb_d = 1'b0;
    if (tick) begin
      prev_d = lvl;
      if (lvl == LVL_NULL) begin
        taken_d = 1'b0;
        if (null_q != NW'(NULL_LIMIT)) null_d = null_q + 1'b1;
        gap_stb_d = (null_q == NW'(NULL_LIMIT - 1));
      end else begin
        null_d = '0;
        if (lvl != prev_q) taken_d = 1'b0;
        else if (hit)      taken_d = 1'b1;
        bit_stb_d = hit;
        if (hit) bit_val_d = (lvl == LVL_ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      null_q    <= '0;
      prev_q    <= LVL_NULL;
      taken_q   <= 1'b0;
      bit_stb_q <= 1'b0;
      bit_val_q <= 1'b0;
      gap_stb_q <= 1'b0;
    end else begin
      pre_q     <= pre_d;
      null_q    <= null_d;
      prev_q    <= prev_d;
      taken_q   <= taken_d;
      bit_stb_q <= bit_stb_d;
      bit_val_q <= bit_val_d;
      gap_stb_q <= gap_stb_d;
    end
  end

  assign bit_stb = bit_stb_q;
  assign bit_val = bit_val_q;
  assign gap_stb = gap_stb_q;

  assert_bit_gap_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_stb_q && gap_stb_q));
  assert_no_back_to_back_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_q |=> !bit_stb_q);
endmodule

// File: rtl/a429_word_framer.sv
module a429_word_framer
  import a429_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 len25,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 gap_stb,
  output logic [WORD_LONG-1:0] shift_word,
  output logic                 word_done
);
  localparam int unsigned CW = $clog2(WORD_LONG);

  logic [WORD_LONG-1:0] sr_q, sr_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 done_q, done_d;
  logic [CW-1:0]        last_idx;

  always_comb begin
    last_idx = len25 ? CW'(WORD_SHORT - 1) : CW'(WORD_LONG - 1);
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (gap_stb) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      sr_d[cnt_q] = bit_val;
      if (cnt_q >= last_idx) begin
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign shift_word = sr_q;
  assign word_done  = done_q;

  assert_done_after_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(bit_stb));
  assert_gap_restarts_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_stb |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/a429_rx_holding.sv
module a429_rx_holding
  import a429_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_done,
  input  logic [WORD_LONG-1:0] shift_word,
  input  logic                 len25,
  input  logic                 filt_en,
  input  logic                 match_x,
  input  logic                 match_y,
  input  logic                 rd_sel,
  input  logic                 rd_en,
  output logic [HALF_W-1:0]    rd_data,
  output logic                 data_ready
);
  logic [HALF_W-1:0]  w1_q, w2_q, w1_d, w2_d;
  logic [LABEL_W-1:0] label_rev;
  logic               par_stat, accept, clr, rdy_q, rdy_d, en_q;

  for (genvar k = 0; k < LABEL_W; k++) begin : g_label
    assign label_rev[LABEL_W-1-k] = shift_word[k];
  end

  always_comb begin
    par_stat = len25 ? ~(^shift_word[WORD_SHORT-1:0]) : ~(^shift_word);
    accept   = word_done &&
               (len25 || !filt_en ||
                ((shift_word[8] == match_y) && (shift_word[9] == match_x)));
    if (len25) begin
      w1_d = {7'b0, par_stat, label_rev};
      w2_d = shift_word[23:8];
    end else begin
      w1_d = {shift_word[12:8], shift_word[30], shift_word[29], par_stat, label_rev};
      w2_d = shift_word[28:13];
    end
    clr   = rd_en && !en_q && rd_sel;
    rdy_d = accept ? 1'b1 : (clr ? 1'b0 : rdy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q  <= '0;
      w2_q  <= '0;
      rdy_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (accept) begin
        w1_q <= w1_d;
        w2_q <= w2_d;
      end
      rdy_q <= rdy_d;
      en_q  <= rd_en;
    end
  end

  assign rd_data    = rd_en ? (rd_sel ? w2_q : w1_q) : '0;
  assign data_ready = rdy_q;

  assert_filter_drops_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && filt_en && !len25 && (shift_word[8] != match_y)) |=> $stable(w1_q) && $stable(w2_q));
  assert_ready_rises_on_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(word_done));
  assert_second_half_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !en_q && rd_sel && !word_done) |=> !rdy_q);
  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: rtl/a429_rx_channel.sv
module a429_rx_channel
  import a429_rx_pkg::*;
#(
  parameter int unsigned SLOW_DIV   = 8,
  parameter int unsigned NULL_LIMIT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_hi,
  input  logic              line_lo,
  input  logic              cfg_rate_slow,
  input  logic              cfg_len25,
  input  logic              cfg_filt_en,
  input  logic              cfg_match_x,
  input  logic              cfg_match_y,
  input  logic              rd_sel,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  output logic              data_ready
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 bit_stb, bit_val, gap_stb, word_done;
  logic [WORD_LONG-1:0] shift_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  a429_bit_recover #(.SLOW_DIV(SLOW_DIV), .NULL_LIMIT(NULL_LIMIT)) u_recover (
    .clk(clk), .rst_n(rst_int_n), .line_hi(line_hi), .line_lo(line_lo),
    .rate_slow(cfg_rate_slow), .bit_stb(bit_stb), .bit_val(bit_val), .gap_stb(gap_stb)
  );

  a429_word_framer u_framer (
    .clk(clk), .rst_n(rst_int_n), .len25(cfg_len25), .bit_stb(bit_stb),
    .bit_val(bit_val), .gap_stb(gap_stb), .shift_word(shift_word), .word_done(word_done)
  );

  a429_rx_holding u_hold (
    .clk(clk), .rst_n(rst_int_n), .word_done(word_done), .shift_word(shift_word),
    .len25(cfg_len25), .filt_en(cfg_filt_en), .match_x(cfg_match_x),
    .match_y(cfg_match_y), .rd_sel(rd_sel), .rd_en(rd_en),
    .rd_data(rd_data), .data_ready(data_ready)
  );
endmodule

// File: tb/a429_rx_channel_tb.sv
module a429_rx_channel_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_hi, line_lo;
  logic        cfg_rate_slow, cfg_len25, cfg_filt_en, cfg_match_x, cfg_match_y;
  logic        rd_sel, rd_en;
  logic [15:0] rd_data;
  logic        data_ready;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  a429_rx_channel u_dut (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .cfg_rate_slow(cfg_rate_slow), .cfg_len25(cfg_len25), .cfg_filt_en(cfg_filt_en),
    .cfg_match_x(cfg_match_x), .cfg_match_y(cfg_match_y),
    .rd_sel(rd_sel), .rd_en(rd_en), .rd_data(rd_data), .data_ready(data_ready)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_lvl(input logic [1:0] lv, input int n);
    repeat (n) begin
      {line_hi, line_lo} = lv;
      repeat (cfg_rate_slow ? 8 : 1) @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits, input int hold);
    for (int i = 0; i < nbits; i++) begin
      drive_lvl(w[i] ? 2'b10 : 2'b01, hold);
      drive_lvl(2'b00, 10 - hold);
    end
    drive_lvl(2'b00, 40);
  endtask

  function automatic logic par_of(input logic [31:0] w, input int nbits);
    int ones = 0;
    for (int i = 0; i < nbits; i++) ones += w[i];
    return (ones % 2) == 0;
  endfunction

  function automatic logic [15:0] exp_w1(input logic [31:0] w, input logic l25);
    logic [7:0] lab;
    for (int k = 0; k < 8; k++) lab[7-k] = w[k];
    if (l25) return {7'b0, par_of(w, 25), lab};
    return {w[12], w[11], w[10], w[9], w[8], w[30], w[29], par_of(w, 32), lab};
  endfunction

  function automatic logic [15:0] exp_w2(input logic [31:0] w, input logic l25);
    return l25 ? w[23:8] : w[28:13];
  endfunction

  task automatic read_half(input logic sel, output logic [15:0] d);
    rd_sel = sel;
    rd_en  = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_word(input string req, input logic [31:0] w, input logic l25);
    logic [15:0] d;
    check({req, " ready set R9"}, 16'(data_ready), 16'd1);
    read_half(1'b0, d);
    check({req, " first half R5/R6/R7"}, d, exp_w1(w, l25));
    check({req, " ready kept after first half R9"}, 16'(data_ready), 16'd1);
    read_half(1'b1, d);
    check({req, " second half R6/R7"}, d, exp_w2(w, l25));
    check({req, " ready cleared R9"}, 16'(data_ready), 16'd0);
  endtask

  task automatic t_reset();
    check("R10 ready after reset", 16'(data_ready), 16'd0);
    check("R8 bus idle while not reading", rd_data, 16'h0000);
  endtask

  task automatic t_fast32();
    send_word(32'hA5C3_1E27, 32, 5);
    expect_word("R6 fast 32-bit even-ish", 32'hA5C3_1E27, 1'b0);
    send_word(32'h0000_0001, 32, 5);
    expect_word("R5 single one", 32'h0000_0001, 1'b0);
  endtask

  task automatic t_repeat_read();
    logic [15:0] a, b;
    send_word(32'h6B29_D4F0, 32, 5);
    read_half(1'b0, a);
    read_half(1'b0, b);
    check("R8 repeated first-half read", b, exp_w1(32'h6B29_D4F0, 1'b0));
    read_half(1'b1, a);
    read_half(1'b1, b);
    check("R8 second half after clear", b, exp_w2(32'h6B29_D4F0, 1'b0));
    check("R8 bus idle after reads", rd_data, 16'h0000);
  endtask

  task automatic t_filter();
    logic [15:0] d;
    cfg_filt_en = 1'b1; cfg_match_x = 1'b1; cfg_match_y = 1'b0;
    send_word(32'h1234_0200, 32, 5);
    expect_word("R4 matching code", 32'h1234_0200, 1'b0);
    send_word(32'h7777_0100, 32, 5);
    check("R4 mismatch keeps ready low", 16'(data_ready), 16'd0);
    read_half(1'b0, d);
    check("R4 mismatch leaves held word", d, exp_w1(32'h1234_0200, 1'b0));
    cfg_len25 = 1'b1;
    send_word(32'h0155_0100, 25, 5);
    expect_word("R4 no filter in 25-bit", 32'h0155_0100, 1'b1);
    cfg_len25 = 1'b0; cfg_filt_en = 1'b0;
  endtask

  task automatic t_slow25();
    cfg_rate_slow = 1'b1; cfg_len25 = 1'b1;
    send_word(32'h01AB_CDEF, 25, 5);
    expect_word("R7 slow 25-bit R1 R2", 32'h01AB_CDEF, 1'b1);
    cfg_rate_slow = 1'b0; cfg_len25 = 1'b0;
  endtask

  task automatic t_overwrite();
    send_word(32'h1111_2222, 32, 5);
    send_word(32'h8642_FDB9, 32, 5);
    expect_word("R9 overwrite unread", 32'h8642_FDB9, 1'b0);
  endtask

  task automatic t_broken();
    for (int i = 0; i < 10; i++) begin
      drive_lvl(2'b10, 5);
      drive_lvl(2'b00, 5);
    end
    drive_lvl(2'b00, 30);
    check("R3 no word from fragment", 16'(data_ready), 16'd0);
    send_word(32'hC0FF_EE01, 32, 5);
    expect_word("R3 word after fragment", 32'hC0FF_EE01, 1'b0);
  endtask

  task automatic t_glitch();
    drive_lvl(2'b10, 1);
    drive_lvl(2'b00, 9);
    send_word(32'h3C3C_A5A5, 32, 2);
    expect_word("R1 glitch ignored, 2-sample bits", 32'h3C3C_A5A5, 1'b0);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 12; i++) begin
      drive_lvl(2'b01, 5);
      drive_lvl(2'b00, 5);
    end
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_word(32'h5A5A_0F0F, 32, 5);
    expect_word("R10 reset discards partial", 32'h5A5A_0F0F, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {line_hi, line_lo} = 2'b00;
    cfg_rate_slow = 1'b0; cfg_len25 = 1'b0; cfg_filt_en = 1'b0;
    cfg_match_x = 1'b0; cfg_match_y = 1'b0;
    rd_sel = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fast32();
    t_repeat_read();
    t_filter();
    t_slow25();
    t_overwrite();
    t_broken();
    t_glitch();
    t_reset_mid();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule